// File: doc/BRIEF.md
# Stream Traffic Statistics Monitor

This block watches one AXI4-Stream link without taking part in it. Each beat that the link hands over (valid and ready both high) adds the number of enabled byte lanes to a byte counter. A beat that also closes a frame adds one to a frame counter. The monitor only listens: it never drives the link's ready.

A one-cycle pulse on the trigger input ends the current measurement interval. The counts reached so far are copied into a report, both counters restart, and the report leaves on a separate byte-wide AXI4-Stream output as a single frame. The frame holds the tag supplied with the trigger, then the byte count, then the frame count. Every field is sent most significant byte first, and the final byte carries the end-of-frame flag. Each report is a whole frame of fixed length and layout. Several monitors fed by one shared trigger therefore produce reports that a later stage can concatenate into one combined frame.

The widths of the lane mask, both counters and the tag are parameters. Counter and tag widths must be whole multiples of eight.

Top module: `stream_stat_mon`

## Requirements
- R1: Each beat with mon_valid and mon_ready both high adds the number of set bits in mon_keep to the byte count, whichever lanes they are. Beats lacking either signal change nothing.
- R2: Each beat with mon_valid, mon_ready and mon_last all high adds one to the frame count. Beats without mon_last leave the frame count alone.
- R3: When trig is high and no report is in progress, the counts held before that edge are captured. From the next cycle rpt_valid is high and shows the first report byte.
- R4: A report is TAG_W/8 + BCNT_W/8 + FCNT_W/8 bytes long. It carries the tag, then the byte count, then the frame count, each field most significant byte first. rpt_last is high on the final byte only.
- R5: While rpt_valid is high and rpt_ready is low, rpt_data and rpt_last hold their values. After the final byte is accepted, rpt_valid goes low the next cycle.
- R6: A monitored beat in the same cycle as an accepted trigger counts toward the new interval and not toward the captured report.
- R7: A trigger while rpt_valid is high is ignored. The report in flight is unchanged and the counters keep accumulating without being cleared.
- R8: Both counters saturate at their all-ones value instead of wrapping.
- R9: After reset rpt_valid and rpt_last are low and both counts are zero.
- R10: The tag in a report is the value on tag in the cycle the trigger was accepted. Later changes on tag do not affect that report.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mon_keep | input | LANES | Byte-lane enables of the monitored link |
| mon_valid | input | 1 | Valid of the monitored link |
| mon_ready | input | 1 | Ready of the monitored link (observed only) |
| mon_last | input | 1 | End-of-frame of the monitored link |
| trig | input | 1 | Snapshot-and-clear request |
| tag | input | TAG_W | Identifier placed at the head of the report |
| rpt_data | output | 8 | Report byte |
| rpt_valid | output | 1 | Report byte valid |
| rpt_ready | input | 1 | Downstream accepts report byte |
| rpt_last | output | 1 | Final byte of the report |

## Verification
The assertions assume trig is only a request: raising it while a report is in flight must have no effect, and the report-side checks depend on that. They also assume rpt_ready may be withdrawn at any cycle. The stall checks therefore expect the output to hold its value on its own, without any cooperation from downstream. The stimulus changes inputs only between clock edges and brings out counter state only through reports. Deliberate triggers during a report, backpressure stalls and beats that coincide with a trigger are each placed at known cycles, so the expected report contents follow directly from the requirements.

// File: rtl/stat_mon_pkg.sv
// Shared types for the stream statistics monitor.
package stat_mon_pkg;
    typedef enum logic {
        RPT_IDLE = 1'b0,
        RPT_BUSY = 1'b1
    } rpt_state_t;
endpackage

// File: rtl/stat_keep_count.sv
// Counts the enabled byte lanes of one beat. The result is zero when en is low.
// Assumes: any lane pattern is allowed. Lanes need not be contiguous.
module stat_keep_count #(
    parameter int LANES = 8,
    parameter int CW    = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0] keep,
    input  logic             en,
    output logic [CW-1:0]    cnt
);
    // Population count of the lane mask, gated by the beat-accepted flag.
    always_comb begin
        cnt = '0;
        for (int i = 0; i < LANES; i++) begin
            if (en && keep[i]) cnt = cnt + CW'(1);
        end
    end
endmodule

// File: rtl/stat_sat_counter.sv
// Saturating accumulator. Clearing restarts the sum at the current
// increment, so an event in the clear cycle belongs to the new interval.
// Assumes: W is wider than IW.
module stat_sat_counter #(
    parameter int W  = 32,
    parameter int IW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [IW-1:0] inc,
    output logic [W-1:0]  cnt
);
    localparam logic [W-1:0] MAX_VAL = {W{1'b1}};

    logic [W:0]   sum;
    logic [W-1:0] base;

    // Next value: (0 or current) plus increment, with a carry-out check.
    always_comb begin
        base = clr ? '0 : cnt;
        sum  = {1'b0, base} + {{(W + 1 - IW){1'b0}}, inc};
    end

    // Register the sum, pinned at all-ones on overflow.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (sum[W]) cnt <= MAX_VAL;
        else             cnt <= sum[W-1:0];
    end

    // R8
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && cnt == MAX_VAL) |=> cnt == MAX_VAL);

    // R1
    no_decrease_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt >= $past(cnt));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && inc == '0) |=> $stable(cnt));
endmodule

// File: rtl/stat_report_ser.sv
// Loads tag and counts into a shift register and sends them MSB first,
// one byte per accepted transfer, marking the final byte as last.
// Assumes: all field widths are multiples of 8. A load while busy is dropped.
module stat_report_ser
    import stat_mon_pkg::*;
#(
    parameter int TAG_W  = 16,
    parameter int BCNT_W = 32,
    parameter int FCNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [TAG_W-1:0]  tag,
    input  logic [BCNT_W-1:0] bcnt,
    input  logic [FCNT_W-1:0] fcnt,
    output logic              busy,
    output logic [7:0]        o_data,
    output logic              o_valid,
    input  logic              o_ready,
    output logic              o_last
);
    localparam int SH_W  = TAG_W + BCNT_W + FCNT_W;
    localparam int NB    = SH_W / 8;
    localparam int IDX_W = $clog2(NB + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);

    rpt_state_t       state;
    logic [SH_W-1:0]  sh;
    logic [IDX_W-1:0] idx;

    // Load on an idle trigger, shift one byte per accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RPT_IDLE;
            sh    <= '0;
            idx   <= '0;
        end else if (state == RPT_IDLE) begin
            if (load) begin
                state <= RPT_BUSY;
                sh    <= {tag, bcnt, fcnt};
                idx   <= '0;
            end
        end else if (o_ready) begin
            if (idx == LAST_IDX) begin
                state <= RPT_IDLE;
            end else begin
                sh  <= sh << 8;
                idx <= idx + IDX_W'(1);
            end
        end
    end

    // Output view of the shift register.
    always_comb begin
        busy    = (state == RPT_BUSY);
        o_valid = busy;
        o_data  = sh[SH_W-1 -: 8];
        o_last  = busy && (idx == LAST_IDX);
    end

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && !o_ready) |=> (o_valid && $stable(o_data) && $stable(o_last)));

    // R5
    end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && o_ready && o_last) |=> !o_valid);

    // R3
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !o_valid) |=> (o_valid && idx == '0));
endmodule

// File: rtl/stream_stat_mon.sv
// Passive byte/frame statistics monitor with triggered, tagged stream report.
// Assumes: the monitored link is observed only. trig is a request that is
// ignored while a report is in flight. Counter and tag widths are multiples of 8.
module stream_stat_mon #(
    parameter int LANES  = 8,
    parameter int BCNT_W = 32,
    parameter int FCNT_W = 32,
    parameter int TAG_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LANES-1:0] mon_keep,
    input  logic             mon_valid,
    input  logic             mon_ready,
    input  logic             mon_last,
    input  logic             trig,
    input  logic [TAG_W-1:0] tag,
    output logic [7:0]       rpt_data,
    output logic             rpt_valid,
    input  logic             rpt_ready,
    output logic             rpt_last
);
    localparam int KCW = $clog2(LANES + 1);

    logic              accept;
    logic              fire;
    logic              busy;
    logic              frame_inc;
    logic [KCW-1:0]    lane_cnt;
    logic [BCNT_W-1:0] byte_cnt;
    logic [FCNT_W-1:0] frame_cnt;

    // Beat handshake seen on the link and trigger acceptance.
    always_comb begin
        accept    = mon_valid && mon_ready;
        frame_inc = accept && mon_last;
        fire      = trig && !busy;
    end

    stat_keep_count #(.LANES(LANES), .CW(KCW)) keep_cnt_i (
        .keep (mon_keep),
        .en   (accept),
        .cnt  (lane_cnt)
    );

    stat_sat_counter #(.W(BCNT_W), .IW(KCW)) byte_ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fire),
        .inc   (lane_cnt),
        .cnt   (byte_cnt)
    );

    stat_sat_counter #(.W(FCNT_W), .IW(1)) frame_ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fire),
        .inc   (frame_inc),
        .cnt   (frame_cnt)
    );

    stat_report_ser #(.TAG_W(TAG_W), .BCNT_W(BCNT_W), .FCNT_W(FCNT_W)) ser_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (fire),
        .tag     (tag),
        .bcnt    (byte_cnt),
        .fcnt    (frame_cnt),
        .busy    (busy),
        .o_data  (rpt_data),
        .o_valid (rpt_valid),
        .o_ready (rpt_ready),
        .o_last  (rpt_last)
    );

    // R7
    busy_trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && rpt_valid && !(rpt_ready && rpt_last)) |=> rpt_valid);

    // R4
    last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_last |-> rpt_valid);
endmodule

// File: tb/stream_stat_mon_tb_top.sv
// Directed bench for the stream statistics monitor (small widths).
module stream_stat_mon_tb_top;
    localparam int LANES = 4;
    localparam int RLEN  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] mon_keep = '0;
    logic       mon_valid = 1'b0;
    logic       mon_ready = 1'b0;
    logic       mon_last = 1'b0;
    logic       trig = 1'b0;
    logic [7:0] tag = '0;
    logic [7:0] rpt_data;
    logic       rpt_valid;
    logic       rpt_ready = 1'b1;
    logic       rpt_last;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    stream_stat_mon #(.LANES(LANES), .BCNT_W(8), .FCNT_W(8), .TAG_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .mon_keep(mon_keep), .mon_valid(mon_valid),
        .mon_ready(mon_ready), .mon_last(mon_last), .trig(trig), .tag(tag),
        .rpt_data(rpt_data), .rpt_valid(rpt_valid), .rpt_ready(rpt_ready),
        .rpt_last(rpt_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One monitored cycle, driven at the falling edge.
    task automatic beat(input logic [3:0] k, input bit v, input bit r, input bit l);
        @(negedge clk);
        mon_keep = k; mon_valid = v; mon_ready = r; mon_last = l;
    endtask

    task automatic idle_link();
        mon_keep = '0; mon_valid = 1'b0; mon_ready = 1'b0; mon_last = 1'b0;
    endtask

    // Trigger with tag t. Returns at the negedge where byte 0 is visible.
    // The tag is changed right after to check R10.
    task automatic fire_trig(input logic [7:0] t);
        @(negedge clk);
        idle_link();
        trig = 1'b1; tag = t;
        @(negedge clk);
        trig = 1'b0; tag = ~t;
    endtask

    // Read a report. Optionally stall each byte once, or poke a trigger plus a beat at byte 1.
    task automatic get_report(input logic [7:0] et, input logic [7:0] eb,
                              input logic [7:0] ef, input bit stall, input bit poke,
                              input string req);
        logic [23:0] exp_w;
        exp_w = {et, eb, ef};
        for (int i = 0; i < RLEN; i++) begin
            if (stall) begin
                rpt_ready = 1'b0;
                @(negedge clk);
                chk(rpt_valid && rpt_data == exp_w[23-8*i -: 8], "R5 stall hold",
                    int'(rpt_data), int'(exp_w[23-8*i -: 8]));
            end
            rpt_ready = 1'b1;
            chk(rpt_valid === 1'b1, {req, " valid"}, int'(rpt_valid), 1);
            chk(rpt_data === exp_w[23-8*i -: 8], {req, " R4 data"}, int'(rpt_data),
                int'(exp_w[23-8*i -: 8]));
            chk(rpt_last === (i == RLEN - 1), "R4 last flag", int'(rpt_last),
                int'(i == RLEN - 1));
            if (poke && i == 1) begin
                trig = 1'b1; tag = 8'h99;
                mon_keep = 4'b0011; mon_valid = 1'b1; mon_ready = 1'b1; mon_last = 1'b1;
            end
            @(negedge clk);
            trig = 1'b0;
            idle_link();
        end
        chk(rpt_valid === 1'b0, "R5 valid drops after last", int'(rpt_valid), 0);
    endtask

    task automatic t_reset();
        chk(rpt_valid === 1'b0, "R9 reset valid", int'(rpt_valid), 0);
        chk(rpt_last === 1'b0, "R9 reset last", int'(rpt_last), 0);
        fire_trig(8'hA5);
        get_report(8'hA5, 8'h00, 8'h00, 1'b0, 1'b0, "R9 R3 R10");
    endtask

    task automatic t_counting();
        beat(4'b1111, 1, 1, 0);   // +4
        beat(4'b0011, 1, 1, 1);   // +2, +1 frame
        beat(4'b1111, 1, 0, 1);   // not accepted
        beat(4'b1111, 0, 1, 1);   // not valid
        beat(4'b1000, 1, 1, 1);   // +1, +1 frame
        beat(4'b0101, 1, 1, 0);   // non-contiguous lanes, +2
        fire_trig(8'h3C);
        get_report(8'h3C, 8'd9, 8'd2, 1'b1, 1'b0, "R1 R2");
    endtask

    task automatic t_same_cycle();
        beat(4'b1111, 1, 1, 1);
        @(negedge clk);
        trig = 1'b1; tag = 8'h5A;
        mon_keep = 4'b0111; mon_valid = 1'b1; mon_ready = 1'b1; mon_last = 1'b1;
        @(negedge clk);
        trig = 1'b0; tag = 8'h00; idle_link();
        get_report(8'h5A, 8'd4, 8'd1, 1'b0, 1'b0, "R6 old interval");
        fire_trig(8'h5B);
        get_report(8'h5B, 8'd3, 8'd1, 1'b0, 1'b0, "R6 new interval");
    endtask

    task automatic t_busy_trig();
        beat(4'b0001, 1, 1, 0);
        fire_trig(8'h11);
        get_report(8'h11, 8'd1, 8'd0, 1'b0, 1'b1, "R7 in flight");
        fire_trig(8'h22);
        get_report(8'h22, 8'd2, 8'd1, 1'b0, 1'b0, "R7 no clear");
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 70; i++) beat(4'b1111, 1, 1, 1);
        fire_trig(8'h77);
        get_report(8'h77, 8'hFF, 8'd70, 1'b0, 1'b0, "R8 bytes");
        for (int i = 0; i < 260; i++) beat(4'b0000, 1, 1, 1);
        fire_trig(8'h78);
        get_report(8'h78, 8'h00, 8'hFF, 1'b0, 1'b0, "R8 frames");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_counting();
        t_same_cycle();
        t_busy_trig();
        t_saturate();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule